// File: doc/BRIEF.md
# Windowed Write-Through Data Cache

This block is a direct-mapped data cache placed between a 32-bit processor load/store port and a slower memory port. It caches only addresses that fall inside one contiguous window, which is set by a base address parameter and a high address parameter. An access outside that window is passed to memory unchanged, and its result is returned to the processor.

Each cache line holds one 32-bit word, a tag and a valid bit. Loads that hit are answered from the cache one cycle after the strobe, without any memory traffic. A load miss inside the window reads the word from memory, returns it, and fills the line. Stores are always written through to memory. A store that hits also updates the selected bytes of the cached word. A store that misses leaves the cache untouched, because the cache does not allocate on a write.

The processor keeps at most one access in flight. On the memory side, a request/acknowledge handshake carries one word per transaction.

Top module: `wtdc_top`

## Requirements
- R1: An access is cacheable only when `WIN_BASE <= cpu_addr <= WIN_HIGH`. Any other load or store always produces exactly one memory transaction, and it never fills or alters a cache line.
- R2: Inside the window, bits `[IDX_W+1:2]` of the address select the line, and the next `TAG_W = log2(window bytes) - IDX_W - 2` bits form the tag, with `IDX_W` between 11 and 14. Two window addresses that differ only in the tag share a line, so each one evicts the other.
- R3: A store that hits in the window updates the cached word and is also sent to memory as one write transaction.
- R4: A store that misses in the window is sent to memory only. The word that was already in that line still hits afterwards with its old data, and a later load of the stored address misses.
- R5: A load that hits returns the cached word with `cpu_ready` high in the cycle right after the strobe cycle, and it makes no memory transaction.
- R6: A load that misses in the window makes one memory read, returns the read word, and installs it in the line with the new tag, so that the next load of that address hits.
- R7: Synchronous reset clears every valid bit and leaves `cpu_ready` and `mem_req` low, so the first load to any line misses.
- R8: On a store hit, only the byte lanes whose `cpu_be` bit is 1 (bit n covers data bits `[8n+7:8n]`) change in the cached word.
- R9: For misses, bypassed accesses and all stores, `cpu_ready` stays low until `mem_ack` arrives, and it goes high in the cycle after the acknowledge. With a memory that acknowledges L cycles after the request rises, a load miss sees ready 2+L cycles after the strobe.
- R10: `cpu_ready` is a single-cycle pulse per access. A strobe given while an access is in progress is ignored and produces neither a memory transaction nor a second ready.
- R11: `mem_req` stays high, with `mem_addr`, `mem_we` and `mem_wdata` held, until `mem_ack`. `mem_we` is 1 for stores. `mem_be` carries the store byte enables, and it is all ones for reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | ADDR_W | Processor byte address (word aligned) |
| cpu_wdata | input | DATA_W | Store data |
| cpu_be | input | DATA_W/8 | Store byte enables |
| cpu_rd | input | 1 | Load strobe |
| cpu_wr | input | 1 | Store strobe |
| cpu_rdata | output | DATA_W | Load data, valid while cpu_ready is high |
| cpu_ready | output | 1 | Access complete pulse |
| mem_req | output | 1 | Memory request, held until acknowledge |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_be | output | DATA_W/8 | Memory byte enables |
| mem_rdata | input | DATA_W | Memory read data, valid with mem_ack |
| mem_ack | input | 1 | Memory acknowledge |

## Verification
The bench builds the block with the smallest index width, `IDX_W` = 11, and a 16 kB window from 0x4000 to 0x7FFF. This leaves a one-bit tag, so each of the 2048 lines can be visited under both of its possible tags within a short run, with every fill, hit and eviction checked. The memory model acknowledges two cycles after each request, which fixes the exact ready latency that misses and stores must show. Store hits are checked under all fifteen non-zero byte-enable patterns. Addresses one word below the window, one byte above it, and aliased onto line 0 probe the window edges.

// File: rtl/wtdc_pkg.sv
package wtdc_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOOK = 2'd1,
    ST_MEM  = 2'd2,
    ST_RESP = 2'd3
  } wtdc_state_e;

endpackage

// File: rtl/wtdc_window.sv
module wtdc_window #(
  parameter int              ADDR_W   = 32,
  parameter logic [ADDR_W-1:0] WIN_BASE = 32'h0001_0000,
  parameter logic [ADDR_W-1:0] WIN_HIGH = 32'h0001_FFFF
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              in_win
);

  always_comb begin
    in_win = (addr >= WIN_BASE) && (addr <= WIN_HIGH);
  end

endmodule

// File: rtl/wtdc_store.sv
module wtdc_store
  import wtdc_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 11,
  parameter int TAG_W  = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                rd_en,
  input  logic [IDX_W-1:0]    rd_idx,
  output logic [TAG_W-1:0]    tag_rd,
  output logic                valid_rd,
  output logic [DATA_W-1:0]   data_rd,
  input  logic                dwr_en,
  input  logic [IDX_W-1:0]    dwr_idx,
  input  logic [DATA_W/8-1:0] dwr_be,
  input  logic [DATA_W-1:0]   dwr_data,
  input  logic                fill_en,
  input  logic [TAG_W-1:0]    fill_tag
);

  localparam int LINES = 1 << IDX_W;
  localparam int LANES = DATA_W / BYTE_W;

  logic [LINES-1:0] valid_vec;
  logic [TAG_W-1:0] tag_mem [LINES];

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_vec <= '0;
      valid_rd  <= 1'b0;
    end else begin
      if (fill_en) valid_vec[dwr_idx] <= 1'b1;
      if (rd_en)   valid_rd <= valid_vec[rd_idx];
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en) tag_mem[dwr_idx] <= fill_tag;
    if (rd_en)   tag_rd <= tag_mem[rd_idx];
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [BYTE_W-1:0] lane_mem [LINES];
    logic [BYTE_W-1:0] lane_q;

    always_ff @(posedge clk) begin
      if (dwr_en && dwr_be[g]) lane_mem[dwr_idx] <= dwr_data[g*BYTE_W +: BYTE_W];
      if (rd_en)               lane_q <= lane_mem[rd_idx];
    end

    assign data_rd[g*BYTE_W +: BYTE_W] = lane_q;
  end

endmodule

// File: rtl/wtdc_ctrl.sv
module wtdc_ctrl
  import wtdc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 11,
  parameter int TAG_W  = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [ADDR_W-1:0]   cpu_addr,
  input  logic [DATA_W-1:0]   cpu_wdata,
  input  logic [DATA_W/8-1:0] cpu_be,
  input  logic                cpu_rd,
  input  logic                cpu_wr,
  input  logic                in_win,
  output logic [DATA_W-1:0]   cpu_rdata,
  output logic                cpu_ready,
  output logic                rd_en,
  output logic [IDX_W-1:0]    rd_idx,
  input  logic [TAG_W-1:0]    tag_rd,
  input  logic                valid_rd,
  input  logic [DATA_W-1:0]   data_rd,
  output logic                dwr_en,
  output logic [IDX_W-1:0]    dwr_idx,
  output logic [DATA_W/8-1:0] dwr_be,
  output logic [DATA_W-1:0]   dwr_data,
  output logic                fill_en,
  output logic [TAG_W-1:0]    fill_tag,
  output logic                mem_req,
  output logic                mem_we,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic [DATA_W-1:0]   mem_wdata,
  output logic [DATA_W/8-1:0] mem_be,
  input  logic [DATA_W-1:0]   mem_rdata,
  input  logic                mem_ack
);

  localparam int LANES = DATA_W / BYTE_W;
  localparam int TAG_LO = IDX_W + 2;

  wtdc_state_e state;

  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [LANES-1:0]  be_q;
  logic              wr_q;
  logic              win_q;
  logic [DATA_W-1:0] resp_q;

  logic accept, hit, look_rd_hit, look_wr_hit, fill;
  logic [TAG_W-1:0] tag_q;

  assign accept      = (state == ST_IDLE) && (cpu_rd || cpu_wr);
  assign tag_q       = addr_q[TAG_LO +: TAG_W];
  assign hit         = win_q && valid_rd && (tag_rd == tag_q);
  assign look_rd_hit = (state == ST_LOOK) && !wr_q && hit;
  assign look_wr_hit = (state == ST_LOOK) && wr_q && hit;
  assign fill        = (state == ST_MEM) && mem_ack && !wr_q && win_q;

  // Request capture: one access in flight, strobes outside IDLE are dropped.
  always_ff @(posedge clk) begin
    if (accept) begin
      addr_q  <= cpu_addr;
      wdata_q <= cpu_wdata;
      be_q    <= cpu_be;
      wr_q    <= cpu_wr;
      win_q   <= in_win;
    end
    if ((state == ST_MEM) && mem_ack && !wr_q) resp_q <= mem_rdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
    end else begin
      unique case (state)
        ST_IDLE: if (cpu_rd || cpu_wr) state <= ST_LOOK;
        ST_LOOK: state <= look_rd_hit ? ST_IDLE : ST_MEM;
        ST_MEM:  if (mem_ack) state <= ST_RESP;
        ST_RESP: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  // Storage lookup issued at the accept edge so tag/data are ready in LOOK.
  assign rd_en  = accept;
  assign rd_idx = cpu_addr[TAG_LO-1:2];

  assign dwr_en   = look_wr_hit || fill;
  assign dwr_idx  = addr_q[TAG_LO-1:2];
  assign dwr_be   = fill ? {LANES{1'b1}} : be_q;
  assign dwr_data = fill ? mem_rdata : wdata_q;
  assign fill_en  = fill;
  assign fill_tag = tag_q;

  assign cpu_ready = look_rd_hit || (state == ST_RESP);
  assign cpu_rdata = (state == ST_RESP) ? resp_q : data_rd;

  assign mem_req   = (state == ST_MEM);
  assign mem_we    = wr_q;
  assign mem_addr  = addr_q;
  assign mem_wdata = wdata_q;
  assign mem_be    = wr_q ? be_q : {LANES{1'b1}};

endmodule

// File: rtl/wtdc_top.sv
module wtdc_top
  import wtdc_pkg::*;
#(
  parameter int                ADDR_W   = 32,
  parameter int                DATA_W   = 32,
  parameter int                IDX_W    = 11,
  parameter logic [ADDR_W-1:0] WIN_BASE = 32'h0001_0000,
  parameter logic [ADDR_W-1:0] WIN_HIGH = 32'h0001_FFFF
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [ADDR_W-1:0]   cpu_addr,
  input  logic [DATA_W-1:0]   cpu_wdata,
  input  logic [DATA_W/8-1:0] cpu_be,
  input  logic                cpu_rd,
  input  logic                cpu_wr,
  output logic [DATA_W-1:0]   cpu_rdata,
  output logic                cpu_ready,
  output logic                mem_req,
  output logic                mem_we,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic [DATA_W-1:0]   mem_wdata,
  output logic [DATA_W/8-1:0] mem_be,
  input  logic [DATA_W-1:0]   mem_rdata,
  input  logic                mem_ack
);

  localparam int WIN_BITS = $clog2(int'(WIN_HIGH - WIN_BASE) + 1);
  localparam int TAG_W    = WIN_BITS - IDX_W - 2;

  logic               in_win;
  logic               rd_en;
  logic [IDX_W-1:0]   rd_idx;
  logic [TAG_W-1:0]   tag_rd;
  logic               valid_rd;
  logic [DATA_W-1:0]  data_rd;
  logic               dwr_en;
  logic [IDX_W-1:0]   dwr_idx;
  logic [DATA_W/8-1:0] dwr_be;
  logic [DATA_W-1:0]  dwr_data;
  logic               fill_en;
  logic [TAG_W-1:0]   fill_tag;

  wtdc_window #(
    .ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE), .WIN_HIGH(WIN_HIGH)
  ) u_window (
    .addr(cpu_addr), .in_win(in_win)
  );

  wtdc_store #(
    .DATA_W(DATA_W), .IDX_W(IDX_W), .TAG_W(TAG_W)
  ) u_store (
    .clk(clk), .rst(rst),
    .rd_en(rd_en), .rd_idx(rd_idx),
    .tag_rd(tag_rd), .valid_rd(valid_rd), .data_rd(data_rd),
    .dwr_en(dwr_en), .dwr_idx(dwr_idx), .dwr_be(dwr_be), .dwr_data(dwr_data),
    .fill_en(fill_en), .fill_tag(fill_tag)
  );

  wtdc_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W), .TAG_W(TAG_W)
  ) u_ctrl (
    .clk(clk), .rst(rst),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_be(cpu_be),
    .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .in_win(in_win),
    .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready),
    .rd_en(rd_en), .rd_idx(rd_idx),
    .tag_rd(tag_rd), .valid_rd(valid_rd), .data_rd(data_rd),
    .dwr_en(dwr_en), .dwr_idx(dwr_idx), .dwr_be(dwr_be), .dwr_data(dwr_data),
    .fill_en(fill_en), .fill_tag(fill_tag),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_be(mem_be),
    .mem_rdata(mem_rdata), .mem_ack(mem_ack)
  );

endmodule

// File: rtl/wtdc_checker.sv
module wtdc_checker #(
  parameter int                ADDR_W   = 32,
  parameter int                DATA_W   = 32,
  parameter logic [ADDR_W-1:0] WIN_BASE = 32'h0001_0000,
  parameter logic [ADDR_W-1:0] WIN_HIGH = 32'h0001_FFFF
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] cpu_addr,
  input logic              cpu_rd,
  input logic              cpu_wr,
  input logic              cpu_ready,
  input logic              mem_req,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_wdata,
  input logic              mem_ack
);

  logic idle_f, pend_wr, pend_out, seen_req, seen_wr;
  logic acc, outside;

  assign acc     = idle_f && (cpu_rd || cpu_wr);
  assign outside = (cpu_addr < WIN_BASE) || (cpu_addr > WIN_HIGH);

  always_ff @(posedge clk) begin
    if (rst) begin
      idle_f   <= 1'b1;
      pend_wr  <= 1'b0;
      pend_out <= 1'b0;
      seen_req <= 1'b0;
      seen_wr  <= 1'b0;
    end else if (acc) begin
      idle_f   <= 1'b0;
      pend_wr  <= cpu_wr;
      pend_out <= outside;
      seen_req <= 1'b0;
      seen_wr  <= 1'b0;
    end else begin
      if (cpu_ready) idle_f <= 1'b1;
      if (mem_req && mem_ack) begin
        seen_req <= 1'b1;
        seen_wr  <= mem_we;
      end
    end
  end

  AST_OUTSIDE_GOES_TO_MEM: assert property (@(posedge clk) disable iff (rst)
    cpu_ready && pend_out |-> seen_req); // R1
  AST_STORE_WRITES_THROUGH: assert property (@(posedge clk) disable iff (rst)
    cpu_ready && pend_wr |-> seen_wr); // R3
  AST_FAST_ONLY_ON_HIT: assert property (@(posedge clk) disable iff (rst)
    cpu_ready && !seen_req |-> $past(acc)); // R5
  AST_ACK_THEN_READY: assert property (@(posedge clk) disable iff (rst)
    mem_req && mem_ack |=> cpu_ready); // R9
  AST_READY_WHEN_BUSY: assert property (@(posedge clk) disable iff (rst)
    cpu_ready |-> !idle_f); // R9
  AST_READY_PULSE: assert property (@(posedge clk) disable iff (rst)
    cpu_ready |=> !cpu_ready); // R10
  AST_REQ_ONLY_BUSY: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> !idle_f); // R10
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we)
                             && $stable(mem_wdata)); // R11

endmodule

bind wtdc_top wtdc_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WIN_BASE(WIN_BASE), .WIN_HIGH(WIN_HIGH)
) u_wtdc_chk (
  .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
  .cpu_ready(cpu_ready), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
  .mem_wdata(mem_wdata), .mem_ack(mem_ack)
);

// File: tb/wtdc_top_bench.sv
module wtdc_top_bench;

  localparam int          IDX_W    = 11;
  localparam int          LINES    = 1 << IDX_W;
  localparam int          LAT      = 2;
  localparam logic [31:0] BASE     = 32'h0000_4000;
  localparam logic [31:0] HIGH     = 32'h0000_7FFF;
  localparam logic [31:0] TAG_STEP = 32'h0000_2000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] cpu_addr = '0, cpu_wdata = '0;
  logic [3:0]  cpu_be = '0;
  logic        cpu_rd = 1'b0, cpu_wr = 1'b0;
  logic [31:0] cpu_rdata;
  logic        cpu_ready;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic [3:0]  mem_be;
  logic [31:0] mem_rdata = '0;
  logic        mem_ack = 1'b0;

  always #4 clk = ~clk;

  wtdc_top #(
    .ADDR_W(32), .DATA_W(32), .IDX_W(IDX_W), .WIN_BASE(BASE), .WIN_HIGH(HIGH)
  ) u_wtdc_top (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_be(cpu_be),
    .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_be(mem_be), .mem_rdata(mem_rdata), .mem_ack(mem_ack)
  );

  int n_chk = 0, n_bad = 0, mem_count = 0, ready_cnt = 0, lat_cnt = 0;
  logic [31:0] model [0:16383];
  logic [31:0] last_addr;
  logic        last_we;
  logic [3:0]  last_be;

  function automatic logic [31:0] merge(input logic [31:0] o, input logic [31:0] n,
                                        input logic [3:0] be);
    logic [31:0] r = o;
    for (int b = 0; b < 4; b++) if (be[b]) r[b*8 +: 8] = n[b*8 +: 8];
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Memory responder: acknowledges LAT cycles after the request rises.
  always @(negedge clk) begin
    if (rst) begin
      mem_ack = 1'b0;
      lat_cnt = 0;
    end else if (mem_ack) begin
      mem_ack = 1'b0;
      lat_cnt = 0;
    end else if (mem_req) begin
      lat_cnt++;
      if (lat_cnt >= LAT) begin
        if (mem_we) model[mem_addr[15:2]] = merge(model[mem_addr[15:2]], mem_wdata, mem_be);
        mem_rdata = model[mem_addr[15:2]];
        last_addr = mem_addr;
        last_we   = mem_we;
        last_be   = mem_be;
        mem_ack   = 1'b1;
        mem_count++;
      end
    end
    if (cpu_ready) ready_cnt++;
  end

  task automatic access(input bit wr, input logic [31:0] a, input logic [31:0] d,
                        input logic [3:0] be, output logic [31:0] rd,
                        output int cyc, output int ops);
    int m0 = mem_count;
    cpu_addr = a; cpu_wdata = d; cpu_be = be;
    cpu_rd = !wr; cpu_wr = wr;
    @(negedge clk);
    cpu_rd = 1'b0; cpu_wr = 1'b0;
    cyc = 1;
    while (!cpu_ready && cyc < 1000) begin
      @(negedge clk);
      cyc++;
    end
    if (!cpu_ready) chk(1'b0, "R9 ready timeout", 32'(cyc), 32'd0);
    rd  = cpu_rdata;
    ops = mem_count - m0;
    @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", n_chk, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] rd, a0, a1, d, exp, old;
    int cyc, ops, m0, r0;
    for (int i = 0; i < 16384; i++) model[i] = i * 32'h9E37_79B1 + 32'h1234_5678;

    repeat (4) @(negedge clk);
    chk(cpu_ready == 1'b0, "R7 ready low in reset", {31'd0, cpu_ready}, 32'd0);
    chk(mem_req == 1'b0, "R7 no request in reset", {31'd0, mem_req}, 32'd0);
    rst = 1'b0;
    @(negedge clk);

    // Every line: first load misses after reset, second hits.
    for (int i = 0; i < LINES; i++) begin
      a0 = BASE + 32'(i) * 4;
      access(1'b0, a0, '0, '0, rd, cyc, ops);
      chk(ops == 1, "R7 first load misses", 32'(ops), 32'd1);
      chk(rd == model[a0[15:2]], "R6 miss data", rd, model[a0[15:2]]);
      chk(cyc == 2 + LAT, "R9 miss latency", 32'(cyc), 32'(2 + LAT));
      if (i == 0) chk(last_be == 4'hF && !last_we, "R11 read enables", {28'd0, last_be}, 32'hF);
      access(1'b0, a0, '0, '0, rd, cyc, ops);
      chk(ops == 0, "R6 filled line hits", 32'(ops), 32'd0);
      chk(cyc == 1, "R5 hit latency", 32'(cyc), 32'd1);
      chk(rd == model[a0[15:2]], "R5 hit data", rd, model[a0[15:2]]);
    end

    // Other tag on every line evicts, then the original tag misses again.
    for (int i = 0; i < LINES; i++) begin
      a0 = BASE + 32'(i) * 4;
      a1 = a0 + TAG_STEP;
      access(1'b0, a1, '0, '0, rd, cyc, ops);
      chk(ops == 1, "R2 other tag misses", 32'(ops), 32'd1);
      chk(rd == model[a1[15:2]], "R2 other tag data", rd, model[a1[15:2]]);
      access(1'b0, a0, '0, '0, rd, cyc, ops);
      chk(ops == 1, "R2 evicted tag misses", 32'(ops), 32'd1);
    end

    // Store hits under all non-zero byte-enable patterns.
    for (int be = 1; be < 16; be++) begin
      a0  = BASE + 32'(be * 37) * 4;
      old = model[a0[15:2]];
      d   = 32'hA5C3_5A3C ^ (32'(be) * 32'h0101_0101);
      exp = merge(old, d, 4'(be));
      access(1'b1, a0, d, 4'(be), rd, cyc, ops);
      chk(ops == 1, "R3 store hit writes memory", 32'(ops), 32'd1);
      chk(cyc == 2 + LAT, "R9 store latency", 32'(cyc), 32'(2 + LAT));
      chk(last_we && last_be == 4'(be), "R11 store enables", {28'd0, last_be}, 32'(be));
      access(1'b0, a0, '0, '0, rd, cyc, ops);
      chk(ops == 0, "R3 line still hits", 32'(ops), 32'd0);
      chk(rd == exp, "R8 byte merge", rd, exp);
    end

    // Store misses do not allocate.
    for (int k = 0; k < 8; k++) begin
      a0  = BASE + 32'(100 + k * 50) * 4;
      a1  = a0 + TAG_STEP;
      old = model[a0[15:2]];
      d   = 32'h0BAD_F00D + 32'(k);
      access(1'b1, a1, d, 4'hF, rd, cyc, ops);
      chk(ops == 1, "R4 store miss writes memory", 32'(ops), 32'd1);
      access(1'b0, a0, '0, '0, rd, cyc, ops);
      chk(ops == 0, "R4 resident line kept", 32'(ops), 32'd0);
      chk(rd == old, "R4 resident data kept", rd, old);
      access(1'b0, a1, '0, '0, rd, cyc, ops);
      chk(ops == 1, "R4 stored word not allocated", 32'(ops), 32'd1);
      chk(rd == d, "R4 stored word in memory", rd, d);
    end

    // Window edges and aliasing from outside.
    for (int j = 0; j < 3; j++) begin
      a0 = (j == 0) ? BASE - 32'd4 : (j == 1) ? HIGH + 32'd1 : BASE + 32'h8000;
      for (int t = 0; t < 2; t++) begin
        access(1'b0, a0, '0, '0, rd, cyc, ops);
        chk(ops == 1, "R1 outside always bypasses", 32'(ops), 32'd1);
        chk(rd == model[a0[15:2]], "R1 outside data", rd, model[a0[15:2]]);
      end
    end
    a0 = BASE;
    access(1'b0, a0, '0, '0, rd, cyc, ops);
    chk(ops == 0, "R1 alias did not fill line 0", 32'(ops), 32'd0);
    a0 = HIGH & ~32'd3;
    access(1'b0, a0, '0, '0, rd, cyc, ops);
    access(1'b0, a0, '0, '0, rd, cyc, ops);
    chk(ops == 0, "R1 top word is cacheable", 32'(ops), 32'd0);
    a0  = HIGH + 32'd1;
    old = model[a0[15:2]];
    d   = 32'h7E57_C0DE;
    access(1'b1, a0, d, 4'b0011, rd, cyc, ops);
    chk(ops == 1 && last_we, "R1 outside store", 32'(ops), 32'd1);
    access(1'b0, a0, '0, '0, rd, cyc, ops);
    chk(rd == merge(old, d, 4'b0011), "R1 outside store data", rd, merge(old, d, 4'b0011));

    // Strobe during a pending miss is ignored.
    a0 = BASE + TAG_STEP + 32'd20;
    m0 = mem_count;
    r0 = ready_cnt;
    cpu_addr = a0; cpu_rd = 1'b1;
    @(negedge clk);
    cpu_rd = 1'b0;
    @(negedge clk);
    cpu_addr = BASE + 32'd36; cpu_rd = 1'b1;
    @(negedge clk);
    cpu_rd = 1'b0;
    for (int w = 0; w < 20 && !cpu_ready; w++) @(negedge clk);
    rd = cpu_rdata;
    chk(rd == model[a0[15:2]], "R10 first access data", rd, model[a0[15:2]]);
    chk(last_addr == a0, "R10 memory saw first address", last_addr, a0);
    repeat (8) @(negedge clk);
    chk(mem_count - m0 == 1, "R10 one transaction", 32'(mem_count - m0), 32'd1);
    chk(ready_cnt - r0 == 1, "R10 one ready pulse", 32'(ready_cnt - r0), 32'd1);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule